// File: doc/BRIEF.md
# Dual-Lane Double-to-Int32 Converter

This block turns a pair of IEEE-754 binary64 numbers into a pair of signed 32-bit integers in one pass. The two doubles arrive side by side in a 128-bit word. The two integers leave side by side in a 64-bit word. Each lane is rounded under a direction chosen at run time.

Each lane is range-checked after rounding. A lane that overflows, or that holds a NaN or an infinity, is flagged invalid. Invalid lanes carry the integer indefinite value. An invalid flag and an inexact flag, each the OR of both lanes, travel with the result.

If an invalid lane is seen while the invalid mask is clear, the block raises an exception request instead of marking the result valid. The datapath is a three-stage pipeline that accepts a new operand pair on every clock.

Top module: `f2i_pair`

## Requirements
- R1: Input bits 63:0 convert into result bits 31:0, and input bits 127:64 convert into result bits 63:32. The two lanes are fully independent.
- R2: A lane whose value is already an integer in [-2^31, 2^31-1] yields that integer in two's complement, with no flags raised.
- R3: A non-integral value is rounded by `in_rmode`: 00 = nearest with ties to even, 01 = toward minus infinity, 10 = toward plus infinity, 11 = toward zero.
- R4: A lane whose value is not an integer raises `out_pe`, provided that lane is not invalid. Exact lanes leave `out_pe` low.
- R5: The range check is applied to the rounded value. A value that rounds to exactly -2^31 is valid. A value that rounds to 2^31 or more, or to less than -2^31, is invalid and raises `out_inv`.
- R6: Every invalid lane returns 0x80000000. When `in_inv_mask` is 1, `out_valid` is still asserted.
- R7: A lane whose exponent field is all ones (a NaN or an infinity) is invalid. It does not raise `out_pe` on its own.
- R8: A zero yields 0 with no flags. A nonzero subnormal yields 0, +1 or -1, depending on the rounding direction, and raises `out_pe`.
- R9: `out_inv` and `out_pe` are each the OR of the two lanes' flags for the same operand pair.
- R10: An invalid lane with `in_inv_mask` = 0 asserts `out_exc` for one cycle and holds `out_valid` low for that operand pair.
- R11: The results for an operand pair strobed at clock edge k appear after edge k+2, and the block accepts a pair on every edge. When neither `out_valid` nor `out_exc` is high, `out_inv` and `out_pe` are both 0.
- R12: A synchronous active-high reset clears every output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand pair strobe |
| in_opnd | input | 128 | Two packed binary64 values; the lower lane is in bits 63:0 |
| in_rmode | input | 2 | Rounding direction, encoded as in R3 |
| in_inv_mask | input | 1 | 1 returns the indefinite value on an invalid lane; 0 requests an exception |
| out_valid | output | 1 | Result strobe |
| out_result | output | 64 | Two packed signed 32-bit results |
| out_inv | output | 1 | Invalid flag (OR of both lanes) |
| out_pe | output | 1 | Inexact flag (OR of both lanes) |
| out_exc | output | 1 | Unmasked-invalid exception request |

## Verification
The bench sweeps quarter-step values under all four rounding directions. A tie-breaking error shows up at values such as 0.5 and 2.5, which would round away from even, and a direction mix-up shows up as negative values moving the wrong way.

It also targets the edges of the 32-bit range, where the ranges are asymmetric. A range check done before rounding would let 2147483647.5 pass in nearest mode. A symmetric limit would wrongly reject -2147483648.5, which ties up to -2^31.

Further cases cover negative subnormals, which must give -1 toward minus infinity, and NaN or infinity beside an inexact lane, which exposes flags that are not merged or that leak precision from an invalid lane. Unmasked overflows check that the valid strobe is withheld, and idle gaps check that the three-cycle alignment holds.

// File: rtl/f2i_pkg.sv
package f2i_pkg;

  // binary64 source format
  localparam int EXP_W = 11;
  localparam int MAN_W = 52;
  localparam int FP_W  = 1 + EXP_W + MAN_W;
  localparam int BIAS  = (1 << (EXP_W - 1)) - 1;

  // integer destination format
  localparam int INT_W = 32;

  // significand with hidden bit and the shift-count width
  localparam int SIG_W = MAN_W + 1;
  localparam int SH_W  = $clog2(SIG_W + 1);

  typedef enum logic [1:0] {
    RND_NEAR = 2'b00,
    RND_DOWN = 2'b01,
    RND_UP   = 2'b10,
    RND_ZERO = 2'b11
  } rmode_e;

  // stage-1 record: truncated magnitude plus the guard information
  typedef struct packed {
    logic             sign;
    logic [INT_W-1:0] ipart;
    logic             rnd;
    logic             stk;
    logic             special;
    logic             huge;
  } split_t;

  localparam logic [INT_W-1:0] INDEF = {1'b1, {(INT_W-1){1'b0}}};

endpackage

// File: rtl/f2i_unpack.sv
module f2i_unpack
  import f2i_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic [FP_W-1:0] fp,
  output split_t          q
);

  logic             sgn;
  logic [EXP_W-1:0] ex;
  logic [MAN_W-1:0] frac;
  logic [SIG_W-1:0] mant;
  logic [SIG_W-1:0] lost;
  logic [SIG_W-1:0] half;
  logic [SH_W-1:0]  shamt;
  int               e_i;
  split_t           nxt;

  always_comb begin
    sgn   = fp[FP_W-1];
    ex    = fp[FP_W-2:MAN_W];
    frac  = fp[MAN_W-1:0];
    mant  = {1'b1, frac};
    e_i   = int'(ex) - BIAS;
    shamt = '0;
    lost  = '0;
    half  = '0;

    nxt         = '0;
    nxt.sign    = sgn;

    if (ex == '1) begin
      // NaN or infinity
      nxt.special = 1'b1;
    end else if (ex == '0) begin
      // zero or subnormal: magnitude far below one half
      nxt.stk = |frac;
    end else if (e_i >= INT_W) begin
      // magnitude at least 2^INT_W, cannot fit after any rounding
      nxt.huge = 1'b1;
    end else if (e_i >= 0) begin
      shamt     = SH_W'(MAN_W - e_i);
      nxt.ipart = INT_W'(mant >> shamt);
      lost      = mant & ((SIG_W'(1) << shamt) - SIG_W'(1));
      half      = SIG_W'(1) << (shamt - SH_W'(1));
      nxt.rnd   = |(lost & half);
      nxt.stk   = |(lost & (half - SIG_W'(1)));
    end else if (e_i == -1) begin
      // value in [0.5, 1)
      nxt.rnd = 1'b1;
      nxt.stk = |frac;
    end else begin
      // value in (0, 0.5)
      nxt.stk = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= nxt;
  end

  AST_SPECIAL_NOT_HUGE: assert property (@(posedge clk) disable iff (rst)
    q.special |-> !q.huge && q.ipart == '0); // R7

endmodule

// File: rtl/f2i_round.sv
module f2i_round
  import f2i_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  split_t           d,
  input  rmode_e           mode,
  output logic [INT_W-1:0] res_o,
  output logic             inv_o,
  output logic             pe_o
);

  logic             inc;
  logic             inexact;
  logic             ovf;
  logic             invalid;
  logic [INT_W:0]   sum;
  logic [INT_W:0]   lim;
  logic [INT_W-1:0] mag;
  logic [INT_W-1:0] sres;

  always_comb begin
    inexact = d.rnd | d.stk;
    unique case (mode)
      RND_NEAR: inc = d.rnd & (d.stk | d.ipart[0]);
      RND_DOWN: inc = d.sign & inexact;
      RND_UP:   inc = ~d.sign & inexact;
      default:  inc = 1'b0;
    endcase
    sum = {1'b0, d.ipart} + (INT_W+1)'(inc);
    // negative side reaches 2^(INT_W-1), positive side stops one short
    lim = (INT_W+1)'(1) << (INT_W - 1);
    if (!d.sign) lim = lim - (INT_W+1)'(1);
    ovf     = d.huge | (sum > lim);
    invalid = d.special | ovf;
    mag     = sum[INT_W-1:0];
    sres    = d.sign ? (~mag + INT_W'(1)) : mag;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_o <= '0;
      inv_o <= 1'b0;
      pe_o  <= 1'b0;
    end else begin
      res_o <= invalid ? INDEF : sres;
      inv_o <= invalid;
      pe_o  <= inexact & ~invalid;
    end
  end

  AST_SIGN_KEPT: assert property (@(posedge clk) disable iff (rst)
    (!inv_o && res_o != '0) |-> res_o[INT_W-1] == $past(d.sign)); // R2

  AST_PE_NOT_INVALID: assert property (@(posedge clk) disable iff (rst)
    pe_o |-> !inv_o); // R7

endmodule

// File: rtl/f2i_pair.sv
module f2i_pair
  import f2i_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_valid,
  input  logic [LANES*FP_W-1:0]  in_opnd,
  input  logic [1:0]             in_rmode,
  input  logic                   in_inv_mask,
  output logic                   out_valid,
  output logic [LANES*INT_W-1:0] out_result,
  output logic                   out_inv,
  output logic                   out_pe,
  output logic                   out_exc
);

  // side-band pipeline alongside the lane datapaths
  logic   vld1, vld2;
  logic   msk1, msk2;
  rmode_e mode1;

  logic [LANES-1:0]       inv_vec;
  logic [LANES-1:0]       pe_vec;
  logic [LANES*INT_W-1:0] res_cat;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld1  <= 1'b0;
      vld2  <= 1'b0;
      msk1  <= 1'b0;
      msk2  <= 1'b0;
      mode1 <= RND_NEAR;
    end else begin
      vld1  <= in_valid;
      vld2  <= vld1;
      msk1  <= in_inv_mask;
      msk2  <= msk1;
      mode1 <= rmode_e'(in_rmode);
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    split_t sp;

    f2i_unpack u_unpack (
      .clk (clk),
      .rst (rst),
      .fp  (in_opnd[l*FP_W +: FP_W]),
      .q   (sp)
    );

    f2i_round u_round (
      .clk   (clk),
      .rst   (rst),
      .d     (sp),
      .mode  (mode1),
      .res_o (res_cat[l*INT_W +: INT_W]),
      .inv_o (inv_vec[l]),
      .pe_o  (pe_vec[l])
    );
  end

  logic inv_any, pe_any, trap;

  always_comb begin
    inv_any = |inv_vec;
    pe_any  = |pe_vec;
    trap    = inv_any & ~msk2;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_result <= '0;
      out_inv    <= 1'b0;
      out_pe     <= 1'b0;
      out_exc    <= 1'b0;
    end else begin
      out_valid  <= vld2 & ~trap;
      out_exc    <= vld2 & trap;
      out_inv    <= vld2 & inv_any;
      out_pe     <= vld2 & pe_any;
      out_result <= res_cat;
    end
  end

  AST_EXC_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(out_valid && out_exc)); // R10

  AST_EXC_HAS_INV: assert property (@(posedge clk) disable iff (rst)
    out_exc |-> out_inv); // R10

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !(out_valid || out_exc) |-> !out_inv && !out_pe); // R11

  AST_LATENCY: assert property (@(posedge clk) disable iff (rst)
    (out_valid || out_exc) |-> $past(in_valid, 3)); // R11

  AST_INDEF_PRESENT: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_inv) |-> (out_result[INT_W-1:0] == INDEF ||
                                out_result[2*INT_W-1:INT_W] == INDEF)); // R6

endmodule

// File: tb/sim_f2i_pair.sv
`timescale 1ns/1ps
module sim_f2i_pair;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [127:0] in_opnd = '0;
  logic [1:0]   in_rmode = 2'b00;
  logic         in_inv_mask = 1'b1;
  logic         out_valid;
  logic [63:0]  out_result;
  logic         out_inv, out_pe, out_exc;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  f2i_pair u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_opnd(in_opnd),
    .in_rmode(in_rmode), .in_inv_mask(in_inv_mask), .out_valid(out_valid),
    .out_result(out_result), .out_inv(out_inv), .out_pe(out_pe), .out_exc(out_exc)
  );

  // expected-value history, index 2 is due for comparison
  logic        h_ov[3], h_ex[3], h_inv[3], h_pe[3];
  logic [63:0] h_res[3];
  string       h_tag[3];

  function automatic void ref_lane(input logic [63:0] b, input logic [1:0] m,
                                   output logic [31:0] r, output logic inv,
                                   output logic pe);
    real v, fl, fr, q;
    if (b[62:52] == 11'h7FF) begin
      r = 32'h8000_0000; inv = 1'b1; pe = 1'b0;
      return;
    end
    v  = $bitstoreal(b);
    fl = $floor(v);
    fr = v - fl;
    case (m)
      2'b00: begin
        if (fr > 0.5)      q = fl + 1.0;
        else if (fr < 0.5) q = fl;
        else               q = ($floor(fl / 2.0) * 2.0 == fl) ? fl : fl + 1.0;
      end
      2'b01:   q = fl;
      2'b10:   q = $ceil(v);
      default: q = (v < 0.0) ? $ceil(v) : fl;
    endcase
    inv = (q > 2147483647.0) || (q < -2147483648.0);
    pe  = !inv && (q != v);
    r   = inv ? 32'h8000_0000 : 32'($rtoi(q));
  endfunction

  task automatic compare();
    logic [68:0] act, exp;
    bit use_res;
    use_res = h_ov[2] | h_ex[2];
    act = {out_valid, out_exc, out_inv, out_pe, use_res ? out_result : 64'd0};
    exp = {h_ov[2], h_ex[2], h_inv[2], h_pe[2], use_res ? h_res[2] : 64'd0};
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: got v=%0b e=%0b i=%0b p=%0b res=%h, expected v=%0b e=%0b i=%0b p=%0b res=%h",
               h_tag[2], act[68], act[67], act[66], act[65], act[63:0],
               exp[68], exp[67], exp[66], exp[65], exp[63:0]);
    end
  endtask

  task automatic step(input logic vld, input logic [63:0] lo, input logic [63:0] hi,
                      input logic [1:0] md, input logic mk, input string tag);
    logic [31:0] r0, r1;
    logic i0, i1, p0, p1, inv, exc;
    @(negedge clk);
    compare();
    for (int k = 2; k > 0; k--) begin
      h_ov[k] = h_ov[k-1]; h_ex[k] = h_ex[k-1]; h_inv[k] = h_inv[k-1];
      h_pe[k] = h_pe[k-1]; h_res[k] = h_res[k-1]; h_tag[k] = h_tag[k-1];
    end
    in_valid    = vld;
    in_opnd     = {hi, lo};
    in_rmode    = md;
    in_inv_mask = mk;
    ref_lane(lo, md, r0, i0, p0);
    ref_lane(hi, md, r1, i1, p1);
    inv = i0 | i1;
    exc = vld & inv & ~mk;
    h_ov[0]  = vld & ~exc;
    h_ex[0]  = exc;
    h_inv[0] = vld & inv;
    h_pe[0]  = vld & (p0 | p1);
    h_res[0] = {r1, r0};
    h_tag[0] = tag;
  endtask

  task automatic idle();
    step(1'b0, 64'd0, 64'd0, 2'b00, 1'b1, "R11 idle");
  endtask

  task automatic all_modes(input logic [63:0] lo, input logic [63:0] hi,
                           input logic mk, input string tag);
    for (int m = 0; m < 4; m++) step(1'b1, lo, hi, 2'(m), mk, tag);
  endtask

  function automatic logic [63:0] rb(input real x);
    return $realtobits(x);
  endfunction

  localparam logic [63:0] QNAN = 64'h7FF8_0000_0000_0000;
  localparam logic [63:0] PINF = 64'h7FF0_0000_0000_0000;
  localparam logic [63:0] NINF = 64'hFFF0_0000_0000_0000;
  localparam logic [63:0] SUBP = 64'h0000_0000_0000_0001;
  localparam logic [63:0] SUBN = 64'h8000_0000_0000_0001;
  localparam logic [63:0] NZRO = 64'h8000_0000_0000_0000;

  initial begin
    for (int k = 0; k < 3; k++) begin
      h_ov[k] = 0; h_ex[k] = 0; h_inv[k] = 0; h_pe[k] = 0; h_res[k] = '0;
      h_tag[k] = "R12 reset";
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    compared++;
    if ({out_valid, out_exc, out_inv, out_pe, out_result} !== 68'd0) begin
      mismatched++;
      $display("FAIL R12: got %h, expected 0",
               {out_valid, out_exc, out_inv, out_pe, out_result});
    end
    rst = 1'b0;

    // R2 R3 R4: quarter-step sweep, all directions
    for (int k = -48; k <= 48; k++)
      all_modes(rb(k / 4.0), rb((k + 1) / 4.0), 1'b1, "R3 sweep");

    // R1: unrelated lane values
    for (int k = 0; k < 40; k++)
      step(1'b1, rb(k * 1000.0 + 0.25), rb(-k * 77.0 - 0.75), 2'(k % 4), 1'b1, "R1 lanes");

    // R2: exact integers including range ends
    all_modes(rb(2147483647.0), rb(-2147483648.0), 1'b1, "R2 exact ends");
    all_modes(rb(0.0), rb(-1.0), 1'b1, "R2 exact small");

    // R5 / R6: rounding near the range ends, masked
    all_modes(rb(2147483647.4), rb(-2147483648.4), 1'b1, "R5 edge");
    all_modes(rb(2147483647.5), rb(-2147483648.5), 1'b1, "R5 tie");
    all_modes(rb(2147483648.0), rb(-2147483649.0), 1'b1, "R6 overflow");
    all_modes(rb(1.0e300), rb(4294967296.0), 1'b1, "R6 huge");

    // R7 / R9: specials beside an inexact lane
    all_modes(QNAN, rb(2.5), 1'b1, "R9 nan+inexact");
    all_modes(rb(-3.25), PINF, 1'b1, "R7 inf");
    all_modes(NINF, rb(7.0), 1'b1, "R7 -inf");

    // R8: zeros and subnormals
    all_modes(SUBP, SUBN, 1'b1, "R8 subnormal");
    all_modes(NZRO, rb(0.0), 1'b1, "R8 zero");
    all_modes(SUBN, rb(0.0), 1'b1, "R8 neg subnormal");

    // R10: unmasked invalid
    all_modes(rb(3000000000.0), rb(1.5), 1'b0, "R10 unmasked");
    all_modes(QNAN, rb(2.0), 1'b0, "R10 unmasked nan");
    all_modes(rb(1.5), rb(-2.5), 1'b0, "R10 no trap");

    // R11: gaps between operands
    for (int k = 0; k < 20; k++) begin
      step(1'b1, rb(k + 0.5), rb(-k - 0.5), 2'(k % 4), 1'(k % 2), "R11 gap");
      if (k % 3 == 0) idle();
    end

    // R2 R4 R5: random values with exponents around the range
    for (int k = 0; k < 3000; k++) begin
      logic [63:0] a, b;
      a = {1'($urandom), 11'(1000 + $urandom % 62), $urandom, 20'($urandom)};
      b = {1'($urandom), 11'(1000 + $urandom % 62), $urandom, 20'($urandom)};
      step(1'b1, a, b, 2'($urandom), 1'($urandom), "R4 random");
    end

    repeat (4) idle();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule